// File: doc/BRIEF.md
# Circular Register-Stack Spill/Fill Controller

This block keeps procedure stack frames in a 64-word register file that is used as a ring. A frame pointer marks the physical base of the current frame. Register accesses give an offset from that base, and the physical slot is the base plus the offset, wrapped modulo 64. The block also keeps the current frame length (1 to 16 words, or 0 straight after reset), the number of valid words held on chip, and a word pointer into backing memory.

Three commands change the frame:
- **Call** opens a new frame that may share its first words with the last words of the caller. Arguments therefore pass without copying.
- **Return** goes back to the caller's frame.
- **Frame-set** resizes the current frame in place.

When a command would leave more than 64 valid words, the oldest words are first written out to memory, one word per acknowledge, at increasing addresses. After that the command takes effect. When a return leaves the caller's frame only partly on chip, the missing words are read back from memory in reverse order. While a spill or fill runs, `busy` is high and the block ignores commands and register writes.

Top module: `rstack_spill_fill`

## Requirements
- R1: After reset, framePtr, frameLen, validCount and stackPtr are all 0, and busy and memReq are low.
- R2: A call with length code L (cmdOp = 1; a code of 0 means 16 words) and overlap V moves framePtr forward by the old frame length minus V, modulo 64, and sets frameLen to the decoded L.
- R3: Right after a call, offsets 0 to V-1 of the new frame read the words the caller held at its last V offsets.
- R4: The register port addresses physical slot (framePtr + offset) mod 64. Reads are combinational, and a write lands on the next clock edge while busy is low. Offset 63 reads the word just below the frame base.
- R5: When validCount plus the command's growth would exceed 64, exactly the excess number of oldest words are written to memory first. Each word goes to the address equal to its absolute stack depth, starting at stackPtr and counting up. validCount ends at 64.
- R6: Frame-set (cmdOp = 3) changes frameLen to the decoded length and leaves framePtr unchanged. It follows the same spill rule as R5.
- R7: Return (cmdOp = 2, length = caller length, overlap = the overlap used by the matching call) moves framePtr back by the caller length minus the overlap. It then reads memory from stackPtr-1 downward until the caller frame is fully on chip. Each word read is restored to its original slot.
- R8: A return never reads memory when stackPtr is 0, even if the caller frame is incomplete.
- R9: busy is high for the whole spill or fill. Commands and register writes presented while busy is high have no effect.
- R10: memReq holds memAddr, memWe and write data stable until memAck. Each acknowledge moves exactly one word and steps stackPtr by one.
- R11: validCount never exceeds 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, taken when busy is low |
| cmdOp | input | 2 | 0 none, 1 call, 2 return, 3 frame-set |
| cmdLen | input | 4 | Frame length code; 0 means 16 |
| cmdOverlap | input | 4 | Words shared with the caller frame |
| busy | output | 1 | Spill or fill in progress |
| regWe | input | 1 | Register write enable |
| regWrAddr | input | 6 | Frame-relative write offset |
| regWrData | input | 32 | Write data |
| regRdAddr | input | 6 | Frame-relative read offset |
| regRdData | output | 32 | Read data |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | 1 for a spill write, 0 for a fill read |
| memAddr | output | 16 | Word address |
| memWdata | output | 32 | Spill data |
| memRdata | input | 32 | Fill data, valid with memAck |
| memAck | input | 1 | One word transferred |
| framePtr | output | 6 | Physical base of the current frame |
| frameLen | output | 5 | Current frame length in words |
| validCount | output | 7 | Valid words on chip |
| stackPtr | output | 16 | Next free memory word |

## Verification
The hardest state to reach is a deep call chain that has wrapped the ring several times, so that spills have already overwritten the physical slots of older frames before those frames are returned to. The bench gets there with a long sweep of calls whose lengths and overlaps follow an arithmetic pattern, varying the memory acknowledge delay along the way. It then unwinds every call, and after each step it compares every frame word with a bench-side picture of the whole stack. A stalled spill with a slow acknowledge is used separately to present a register write and a frame-set while busy is high, and both are then shown to have had no effect.

// File: rtl/rstack_pkg.sv
package rstack_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_CALL  = 2'd1,
    OP_RET   = 2'd2,
    OP_FRAME = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SPILL,
    ST_FILL
  } state_e;

  // strobes from control to the register-file datapath
  typedef struct packed {
    logic userWr;
    logic fillWr;
  } strobes_t;

endpackage

// File: rtl/rstack_ctrl.sv
module rstack_ctrl
  import rstack_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int MAX_FRAME = 16,
  parameter int MEM_AW    = 16,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CODE_W   = $clog2(MAX_FRAME),
  localparam int LEN_W    = $clog2(MAX_FRAME + 1),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int CW       = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [CODE_W-1:0] cmdLen,
  input  logic [CODE_W-1:0] cmdOverlap,
  input  logic              regWe,
  input  logic              memAck,
  output strobes_t          strb,
  output logic [IDX_W-1:0]  baseIdx,
  output logic [IDX_W-1:0]  bottomIdx,
  output logic [IDX_W-1:0]  fillIdx,
  output logic              busy,
  output logic              memReq,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [LEN_W-1:0]  frameLen,
  output logic [CNT_W-1:0]  validCount,
  output logic [MEM_AW-1:0] stackPtr
);

  state_e            state;
  logic [IDX_W-1:0]  fp, pendFp, nextFp;
  logic [LEN_W-1:0]  fl, pendLen, newLen, ovLen;
  logic [CNT_W-1:0]  valid;
  logic [MEM_AW-1:0] memPtr;
  logic [CW-1:0]     spillLeft, sumValid, excess;
  logic              accept, needSpill, needFill;
  op_e               op;

  // decode the command into the frame it would produce
  always_comb begin
    op       = op_e'(cmdOp);
    newLen   = (cmdLen == '0) ? LEN_W'(MAX_FRAME) : LEN_W'(cmdLen);
    ovLen    = LEN_W'(cmdOverlap);
    nextFp   = fp;
    sumValid = CW'(valid);
    case (op)
      OP_CALL: begin
        nextFp   = fp + IDX_W'(fl) - IDX_W'(ovLen);
        sumValid = CW'(valid) + CW'(newLen) - CW'(ovLen);
      end
      OP_RET: begin
        nextFp   = fp + IDX_W'(ovLen) - IDX_W'(newLen);
        sumValid = CW'(valid) + CW'(ovLen) - CW'(fl);
      end
      OP_FRAME: begin
        sumValid = CW'(valid) + CW'(newLen) - CW'(fl);
      end
      default: ;
    endcase
    accept    = cmdValid && (state == ST_IDLE) && (op != OP_NONE);
    needSpill = (op != OP_RET) && (sumValid > CW'(DEPTH));
    excess    = sumValid - CW'(DEPTH);
    needFill  = (op == OP_RET) && (sumValid < CW'(newLen)) && (memPtr != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      fp        <= '0;
      fl        <= '0;
      valid     <= '0;
      memPtr    <= '0;
      pendFp    <= '0;
      pendLen   <= '0;
      spillLeft <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (needSpill) begin
              pendFp    <= nextFp;
              pendLen   <= newLen;
              spillLeft <= excess;
              state     <= ST_SPILL;
            end else begin
              fp    <= nextFp;
              fl    <= newLen;
              valid <= CNT_W'(sumValid);
              if (needFill) state <= ST_FILL;
            end
          end
        end
        ST_SPILL: begin
          if (memAck) begin
            memPtr    <= memPtr + MEM_AW'(1);
            valid     <= valid - CNT_W'(1);
            spillLeft <= spillLeft - CW'(1);
            if (spillLeft == CW'(1)) begin
              fp    <= pendFp;
              fl    <= pendLen;
              valid <= CNT_W'(DEPTH);
              state <= ST_IDLE;
            end
          end
        end
        ST_FILL: begin
          if (memAck) begin
            memPtr <= memPtr - MEM_AW'(1);
            valid  <= valid + CNT_W'(1);
            if ((valid + CNT_W'(1) >= CNT_W'(fl)) || (memPtr == MEM_AW'(1)))
              state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ring positions of the oldest valid word and the slot just below it
  assign bottomIdx = fp + IDX_W'(fl) - IDX_W'(valid);
  assign fillIdx   = bottomIdx - IDX_W'(1);
  assign baseIdx   = fp;

  assign busy    = (state != ST_IDLE);
  assign memReq  = busy;
  assign memWe   = (state == ST_SPILL);
  assign memAddr = (state == ST_FILL) ? (memPtr - MEM_AW'(1)) : memPtr;

  assign strb.userWr = regWe && (state == ST_IDLE);
  assign strb.fillWr = (state == ST_FILL) && memAck;

  assign frameLen   = fl;
  assign validCount = valid;
  assign stackPtr   = memPtr;

endmodule

// File: rtl/rstack_dp.sv
module rstack_dp
  import rstack_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  strobes_t          strb,
  input  logic [IDX_W-1:0]  baseIdx,
  input  logic [IDX_W-1:0]  wrOfs,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdOfs,
  output logic [DATA_W-1:0] rdData,
  input  logic [IDX_W-1:0]  spillIdx,
  output logic [DATA_W-1:0] spillData,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [DATA_W-1:0] fillData
);

  logic [DATA_W-1:0] rows [DEPTH];
  logic [IDX_W-1:0]  wrIdx, rdIdx;

  assign wrIdx = baseIdx + wrOfs;
  assign rdIdx = baseIdx + rdOfs;

  for (genvar g = 0; g < DEPTH; g++) begin : gen_row
    logic [DATA_W-1:0] word;
    always_ff @(posedge clk) begin
      if (strb.fillWr && (fillIdx == IDX_W'(g)))
        word <= fillData;
      else if (strb.userWr && (wrIdx == IDX_W'(g)))
        word <= wrData;
    end
    assign rows[g] = word;
  end

  assign rdData    = rows[rdIdx];
  assign spillData = rows[spillIdx];

endmodule

// File: rtl/rstack_spill_fill.sv
module rstack_spill_fill
  import rstack_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int MAX_FRAME = 16,
  parameter int DATA_W    = 32,
  parameter int MEM_AW    = 16,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CODE_W   = $clog2(MAX_FRAME),
  localparam int LEN_W    = $clog2(MAX_FRAME + 1),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [CODE_W-1:0] cmdLen,
  input  logic [CODE_W-1:0] cmdOverlap,
  output logic              busy,
  input  logic              regWe,
  input  logic [IDX_W-1:0]  regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [IDX_W-1:0]  regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              memReq,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic [IDX_W-1:0]  framePtr,
  output logic [LEN_W-1:0]  frameLen,
  output logic [CNT_W-1:0]  validCount,
  output logic [MEM_AW-1:0] stackPtr
);

  strobes_t         strb;
  logic [IDX_W-1:0] baseIdx, bottomIdx, fillIdx;

  rstack_ctrl #(
    .DEPTH(DEPTH), .MAX_FRAME(MAX_FRAME), .MEM_AW(MEM_AW)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdLen(cmdLen), .cmdOverlap(cmdOverlap),
    .regWe(regWe), .memAck(memAck),
    .strb(strb), .baseIdx(baseIdx), .bottomIdx(bottomIdx), .fillIdx(fillIdx),
    .busy(busy), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .frameLen(frameLen), .validCount(validCount), .stackPtr(stackPtr)
  );

  rstack_dp #(
    .DEPTH(DEPTH), .DATA_W(DATA_W)
  ) i_dp (
    .clk(clk), .strb(strb), .baseIdx(baseIdx),
    .wrOfs(regWrAddr), .wrData(regWrData),
    .rdOfs(regRdAddr), .rdData(regRdData),
    .spillIdx(bottomIdx), .spillData(memWdata),
    .fillIdx(fillIdx), .fillData(memRdata)
  );

  assign framePtr = baseIdx;

endmodule

// File: rtl/rstack_chk.sv
module rstack_chk #(
  parameter int DEPTH     = 64,
  parameter int MAX_FRAME = 16,
  parameter int DATA_W    = 32,
  parameter int MEM_AW    = 16,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int LEN_W    = $clog2(MAX_FRAME + 1),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              memReq,
  input logic              memWe,
  input logic [MEM_AW-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memAck,
  input logic [IDX_W-1:0]  framePtr,
  input logic [LEN_W-1:0]  frameLen,
  input logic [CNT_W-1:0]  validCount,
  input logic [MEM_AW-1:0] stackPtr
);

  // R11
  valid_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    validCount <= CNT_W'(DEPTH));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe)
                          && (!memWe || $stable(memWdata)));

  // R5
  spill_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memAck |=> stackPtr == $past(stackPtr) + MEM_AW'(1));

  // R7
  fill_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe && memAck |=> stackPtr == $past(stackPtr) - MEM_AW'(1));

  // R8
  fill_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe |-> stackPtr != '0);

  // R9
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !memAck |=> $stable(framePtr) && $stable(frameLen));

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameLen <= LEN_W'(MAX_FRAME));

endmodule

bind rstack_spill_fill rstack_chk #(
  .DEPTH(DEPTH), .MAX_FRAME(MAX_FRAME), .DATA_W(DATA_W), .MEM_AW(MEM_AW)
) i_chk (.*);

// File: tb/test_rstack_spill_fill.sv
module test_rstack_spill_fill;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = '0;
  logic [3:0]  cmdLen = '0;
  logic [3:0]  cmdOverlap = '0;
  logic        busy;
  logic        regWe = 1'b0;
  logic [5:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic [5:0]  regRdAddr = '0;
  logic [31:0] regRdData;
  logic        memReq, memWe;
  logic [15:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic [5:0]  framePtr;
  logic [4:0]  frameLen;
  logic [6:0]  validCount;
  logic [15:0] stackPtr;

  always #10 clk = ~clk;

  rstack_spill_fill i_rstack_spill_fill (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdLen(cmdLen),
    .cmdOverlap(cmdOverlap), .busy(busy), .regWe(regWe), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .framePtr(framePtr), .frameLen(frameLen),
    .validCount(validCount), .stackPtr(stackPtr)
  );

  logic [31:0] benchMem [0:1023];
  logic [31:0] modelStk [0:1023];
  int mFp = 0, mFl = 0, mValid = 0, depth = 0;
  int csLen [0:63];
  int csOv [0:63];
  int ackDelay = 0, waitC = 0;
  int tests = 0, fails = 0;

  // memory model: acknowledges after ackDelay idle cycles
  initial begin
    forever begin
      @(negedge clk);
      if (!rstN) begin
        memAck = 1'b0; waitC = 0;
      end else if (memAck) begin
        memAck = 1'b0; waitC = 0;
      end else if (memReq) begin
        if (waitC >= ackDelay) begin
          if (memWe) benchMem[memAddr[9:0]] = memWdata;
          else       memRdata = benchMem[memAddr[9:0]];
          memAck = 1'b1;
        end else begin
          waitC++;
        end
      end
    end
  end

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  function automatic int wrap64(int v);
    return ((v % 64) + 64) % 64;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkState(string tag);
    chk(tag, "framePtr", framePtr, wrap64(mFp));
    chk(tag, "frameLen", frameLen, mFl);
    chk(tag, "validCount", validCount, mValid);
    chk(tag, "stackPtr", stackPtr, mFp + mFl - mValid);
    chk("R11", "validCount<=64", (validCount <= 7'd64) ? 1 : 0, 1);
  endtask

  task automatic issue(int op, int code, int ov);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op[1:0]; cmdLen = code[3:0]; cmdOverlap = ov[3:0];
    @(negedge clk);
    cmdValid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic readCheck(string tag, int rel, int absIdx);
    @(negedge clk);
    regRdAddr = rel[5:0];
    #2;
    chk(tag, "word", regRdData, modelStk[absIdx]);
  endtask

  task automatic checkFrame(string tag);
    for (int i = 0; i < mFl; i++) readCheck(tag, i, mFp + i);
  endtask

  task automatic writeWords(int from, int k);
    for (int i = from; i < mFl; i++) begin
      logic [31:0] v;
      v = 32'(k * 65536 + i + 7);
      @(negedge clk);
      regWe = 1'b1; regWrAddr = i[5:0]; regWrData = v;
      modelStk[mFp + i] = v;
    end
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic modelCall(int code, int ov);
    int nl;
    nl = (code == 0) ? 16 : code;
    csLen[depth] = mFl; csOv[depth] = ov; depth++;
    mFp = mFp + mFl - ov;
    mValid = (mValid + nl - ov > 64) ? 64 : mValid + nl - ov;
    mFl = nl;
  endtask

  task automatic doCall(int code, int ov);
    modelCall(code, ov);
    issue(1, code, ov);
  endtask

  task automatic doFrame(int code);
    int nl;
    nl = (code == 0) ? 16 : code;
    mValid = (mValid + nl - mFl > 64) ? 64 : mValid + nl - mFl;
    mFl = nl;
    issue(3, code, 0);
  endtask

  task automatic doRet();
    int cl, ov, tmp, top;
    depth--;
    cl = csLen[depth]; ov = csOv[depth];
    tmp = mValid + ov - mFl;
    mFp = mFp + ov - cl;
    mFl = cl;
    top = mFp + cl;
    mValid = (tmp < cl) ? cl : tmp;
    if (mValid > top) mValid = top;
    issue(2, cl % 16, ov);
  endtask

  task automatic resetDut();
    rstN = 1'b0;
    mFp = 0; mFl = 0; mValid = 0; depth = 0; ackDelay = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    resetDut();
    @(negedge clk);
    // R1 reset state
    chk("R1", "framePtr", framePtr, 0);
    chk("R1", "frameLen", frameLen, 0);
    chk("R1", "validCount", validCount, 0);
    chk("R1", "stackPtr", stackPtr, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "memReq", memReq, 0);

    // R8: return below an empty memory must not fill
    doCall(4, 0);
    checkState("R2");
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'd2; cmdLen = 4'd4; cmdOverlap = 4'd0;
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R8", "busy", busy, 0);
    chk("R8", "framePtr", framePtr, 60);
    chk("R8", "validCount", validCount, 0);
    chk("R8", "stackPtr", stackPtr, 0);
    chk("R8", "frameLen", frameLen, 4);

    // deep call chain with spills, then unwind with fills
    resetDut();
    doCall(8, 0);
    checkState("R2");
    writeWords(0, 0);
    for (int k = 1; k <= 22; k++) begin
      int code, nl, ov;
      ackDelay = k % 3;
      code = (k * 5 + 3) % 16;
      nl = (code == 0) ? 16 : code;
      ov = k % 4;
      if (ov > mFl) ov = mFl;
      if (ov > nl) ov = nl;
      doCall(code, ov);
      checkState("R2");
      for (int i = 0; i < ov; i++) readCheck("R3", i, mFp + i);
      writeWords(ov, k);
      checkFrame("R4");
      if (mValid > mFl) readCheck("R4", 63, mFp - 1);
      if (k == 10) begin
        int oldFl;
        oldFl = mFl;
        doFrame(0);
        checkState("R6");
        writeWords(oldFl, 100);
        checkFrame("R6");
      end
    end
    for (int a = 0; a < mFp + mFl - mValid; a++)
      chk("R5", "spilled word", benchMem[a], modelStk[a]);
    for (int r = 0; r < 22; r++) begin
      ackDelay = r % 3;
      doRet();
      checkState("R7");
      checkFrame("R7");
    end

    // R9/R10: stalled spill with ignored stimulus
    resetDut();
    for (int j = 0; j < 4; j++) begin
      doCall(0, 0);
      writeWords(0, 50 + j);
    end
    checkState("R5");
    ackDelay = 5;
    modelCall(8, 0);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'd1; cmdLen = 4'd8; cmdOverlap = 4'd0;
    @(negedge clk);
    chk("R9", "busy", busy, 1);
    regWe = 1'b1; regWrAddr = 6'd0; regWrData = 32'hdead0000;
    cmdValid = 1'b1; cmdOp = 2'd3; cmdLen = 4'd2;
    @(negedge clk);
    regWe = 1'b0; cmdValid = 1'b0;
    while (busy) @(negedge clk);
    checkState("R9");
    chk("R10", "stackPtr after slow spill", stackPtr, 8);
    for (int a = 0; a < 8; a++)
      chk("R10", "spilled word", benchMem[a], modelStk[a]);
    ackDelay = 0;
    doRet();
    checkState("R9");
    checkFrame("R9");

    report();
    $finish;
  end

endmodule